// File: doc/BRIEF.md
# Multichannel Scan Convert Timing Generator

This block paces one acquisition scan over a programmable list of analog input channels. A start trigger, issued once per model time step, launches a scan. The block raises a one-cycle scan strobe. It then raises one convert strobe per list entry and presents the channel number for each conversion. The gap between successive convert strobes is a programmable number of ticks of a selected timebase. All timebases are clock enables derived from the single system clock.

The controller writes a configuration word and the channel list while the block is idle. The configuration holds the timebase select, tick count, initial-delay flag, strobe-visibility select and list length. A downstream converter uses each convert strobe and the channel number that comes with it. Observation logic can watch either strobe. A busy flag marks the scan in flight. Triggers, configuration writes and list writes that arrive during a scan are dropped.

Top module: `scan_conv_timer`

## Requirements
- R1: An accepted start (start high while busy is low) produces exactly one scan strobe, one clock wide, in the cycle after the start is sampled. Call that cycle scan cycle 0.
- R2: A scan with list length N produces N convert strobes, each one clock wide. The channel number on conv_chan in the cycle of convert strobe j equals list entry j, for j = 0..N-1, whatever values the list holds. A written length above MAX_LIST is stored as MAX_LIST.
- R3: Convert strobes are spaced by T*P system cycles, where T is the tick count and P depends on the timebase select: 0 gives FAST_DIV, 1 gives 2*FAST_DIV, 2 gives SLOW_DIV, 3 gives 2*SLOW_DIV.
- R4: With the delay flag at 0 the first convert strobe is in scan cycle 0, the same cycle as the scan strobe. With the flag at 1 it is in scan cycle T*P.
- R5: A tick count of 0 or 1 behaves as a tick count of 2.
- R6: In the strobe select, bit 0 lets the convert strobe reach its port and bit 1 lets the scan strobe reach its port. A masked strobe stays low, and conv_chan still updates at every conversion.
- R7: busy is high from scan cycle 0 through the cycle of the last convert strobe, and low in the cycle after it.
- R8: A start that arrives while busy is high has no effect on strobes, channel numbers or busy.
- R9: A list length of 0 gives a scan strobe and no convert strobe, with busy high for scan cycle 0 only.
- R10: Configuration and list writes made while busy is high are dropped. The next scan runs with the values held before those writes.
- R11: After reset the strobes and busy are low and conv_chan is 0. The configuration is timebase select 0, tick count 20, delay flag 1, strobe select 3 and list length 1, and every list entry is 0.
- R12: conv_chan keeps the last issued channel number until the next conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write all configuration fields |
| cfg_tb_sel | input | 2 | Timebase select (0 fast, 1 fast/2, 2 slow, 3 slow/2) |
| cfg_ticks | input | TICK_W | Timebase ticks per convert interval |
| cfg_delay | input | 1 | 1 delays the first convert strobe by one interval |
| cfg_out_sel | input | 2 | Bit 0 enables convert strobe, bit 1 enables scan strobe |
| cfg_len | input | $clog2(MAX_LIST+1) | Number of channel list entries |
| list_we | input | 1 | Write one channel list entry |
| list_addr | input | $clog2(MAX_LIST) | List entry position |
| list_data | input | CH_W | Channel number for that entry |
| start | input | 1 | Scan trigger |
| scan_strobe | output | 1 | One-cycle scan start strobe |
| conv_strobe | output | 1 | One-cycle convert strobe |
| conv_chan | output | CH_W | Channel number of the current or last conversion |
| busy | output | 1 | Scan in progress |

## Verification
The bench builds the block with FAST_DIV=2, SLOW_DIV=5 and MAX_LIST=8. With these values all four timebases give intervals of a few tens of cycles, so every select value is checked at exact cycle positions within a short run. The small list size lets one scan fill the list completely and also exercise the length clamp. The reset configuration is kept as it is, so the default 20-tick interval is checked too.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    TB_FAST      = 2'd0,
    TB_FAST_HALF = 2'd1,
    TB_SLOW      = 2'd2,
    TB_SLOW_HALF = 2'd3
  } tb_sel_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_LAST = 2'd2
  } seq_state_t;

  localparam int OUT_CONV_BIT  = 0;
  localparam int OUT_SCAN_BIT  = 1;
  localparam int DEFAULT_TICKS = 20;
  localparam int MIN_TICKS     = 2;

endpackage

// File: rtl/scan_prescaler.sv
module scan_prescaler #(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick,
  output logic tick_half
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          half_q, half_d;

  assign tick      = (cnt_q == CW'(DIV - 1));
  assign tick_half = tick & half_q;

  always_comb begin
    cnt_d  = cnt_q;
    half_d = half_q;
    if (restart) begin
      cnt_d  = '0;
      half_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      half_d = ~half_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
    end
  end

  // R3: the halved enable never fires twice in a row
  a_r3_half_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick_half |=> !tick_half);

endmodule

// File: rtl/scan_timebase.sv
module scan_timebase
  import scan_pkg::*;
#(
  parameter int FAST_DIV = 5,
  parameter int SLOW_DIV = 1000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    restart,
  input  tb_sel_t sel,
  output logic    tb_tick
);
  localparam int NBASE = 2;

  logic [NBASE-1:0] base_tick;
  logic [NBASE-1:0] base_half;

  for (genvar g = 0; g < NBASE; g++) begin : g_base
    localparam int GDIV = (g == 0) ? FAST_DIV : SLOW_DIV;
    scan_prescaler #(.DIV(GDIV)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .tick      (base_tick[g]),
      .tick_half (base_half[g])
    );
  end

  always_comb begin
    unique case (sel)
      TB_FAST:      tb_tick = base_tick[0];
      TB_FAST_HALF: tb_tick = base_half[0];
      TB_SLOW:      tb_tick = base_tick[1];
      TB_SLOW_HALF: tb_tick = base_half[1];
      default:      tb_tick = base_tick[0];
    endcase
  end

endmodule

// File: rtl/scan_spacer.sv
module scan_spacer
  import scan_pkg::*;
#(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              tb_tick,
  input  logic [TICK_W-1:0] ticks,
  output logic              fire
);
  logic [TICK_W-1:0] eff;
  logic [TICK_W-1:0] cnt_q, cnt_d;

  // R5: tick counts below the minimum are raised to it
  assign eff  = (ticks < TICK_W'(MIN_TICKS)) ? TICK_W'(MIN_TICKS) : ticks;
  assign fire = tb_tick && (cnt_q == eff - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)      cnt_d = '0;
    else if (fire)    cnt_d = '0;
    else if (tb_tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r5_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

endmodule

// File: rtl/scan_chanlist.sv
module scan_chanlist #(
  parameter int MAX_LIST = 16,
  parameter int CH_W     = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(MAX_LIST)-1:0] wr_addr,
  input  logic [CH_W-1:0]             wr_data,
  input  logic [$clog2(MAX_LIST)-1:0] rd_addr,
  output logic [CH_W-1:0]             rd_data
);
  logic [CH_W-1:0] ent_q [MAX_LIST];

  for (genvar e = 0; e < MAX_LIST; e++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_addr == $clog2(MAX_LIST)'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ent_q[e] <= '0;
      else if (sel) ent_q[e] <= wr_data;
    end
  end

  assign rd_data = ent_q[rd_addr];

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_pkg::*;
#(
  parameter int MAX_LIST = 16,
  parameter int CH_W     = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          fire,
  input  logic                          delay,
  input  logic [$clog2(MAX_LIST+1)-1:0] len,
  input  logic [CH_W-1:0]               rd_data,
  output logic [$clog2(MAX_LIST)-1:0]   rd_addr,
  output logic                          launch,
  output logic                          scan_p,
  output logic                          conv_p,
  output logic [CH_W-1:0]               chan,
  output logic                          busy
);
  localparam int LW = $clog2(MAX_LIST + 1);
  localparam int AW = $clog2(MAX_LIST);

  seq_state_t      state_q, state_d;
  logic [LW-1:0]   idx_q, idx_d;
  logic            scan_q, scan_d;
  logic            conv_q, conv_d;
  logic [CH_W-1:0] chan_q, chan_d;

  assign launch  = (state_q == SEQ_IDLE) && start;
  assign rd_addr = (state_q == SEQ_IDLE) ? '0 : idx_q[AW-1:0];

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    scan_d  = 1'b0;
    conv_d  = 1'b0;
    chan_d  = chan_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          scan_d = 1'b1;
          idx_d  = '0;
          if (len == '0) begin
            state_d = SEQ_LAST;
          end else if (!delay) begin
            conv_d  = 1'b1;
            chan_d  = rd_data;
            idx_d   = LW'(1);
            state_d = (len == LW'(1)) ? SEQ_LAST : SEQ_RUN;
          end else begin
            state_d = SEQ_RUN;
          end
        end
      end
      SEQ_RUN: begin
        if (fire) begin
          conv_d = 1'b1;
          chan_d = rd_data;
          idx_d  = idx_q + 1'b1;
          if (idx_q + 1'b1 == len) state_d = SEQ_LAST;
        end
      end
      SEQ_LAST: state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      scan_q  <= 1'b0;
      conv_q  <= 1'b0;
      chan_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      scan_q  <= scan_d;
      conv_q  <= conv_d;
      chan_q  <= chan_d;
    end
  end

  assign scan_p = scan_q;
  assign conv_p = conv_q;
  assign chan   = chan_q;
  assign busy   = (state_q != SEQ_IDLE);

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !scan_q);

  a_r9_empty_list: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && len == '0) |=> (!conv_q && state_q == SEQ_LAST));

endmodule

// File: rtl/scan_conv_timer.sv
module scan_conv_timer
  import scan_pkg::*;
#(
  parameter int FAST_DIV = 5,
  parameter int SLOW_DIV = 1000,
  parameter int MAX_LIST = 16,
  parameter int CH_W     = 6,
  parameter int TICK_W   = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [1:0]                    cfg_tb_sel,
  input  logic [TICK_W-1:0]             cfg_ticks,
  input  logic                          cfg_delay,
  input  logic [1:0]                    cfg_out_sel,
  input  logic [$clog2(MAX_LIST+1)-1:0] cfg_len,
  input  logic                          list_we,
  input  logic [$clog2(MAX_LIST)-1:0]   list_addr,
  input  logic [CH_W-1:0]               list_data,
  input  logic                          start,
  output logic                          scan_strobe,
  output logic                          conv_strobe,
  output logic [CH_W-1:0]               conv_chan,
  output logic                          busy
);
  localparam int LW = $clog2(MAX_LIST + 1);
  localparam int AW = $clog2(MAX_LIST);

  tb_sel_t           sel_q, sel_d;
  logic [TICK_W-1:0] ticks_q, ticks_d;
  logic              delay_q, delay_d;
  logic [1:0]        outsel_q, outsel_d;
  logic [LW-1:0]     len_q, len_d;

  logic            cfg_ok;
  logic            list_ok;
  logic            launch;
  logic            tb_tick;
  logic            fire;
  logic            scan_p;
  logic            conv_p;
  logic [AW-1:0]   rd_addr;
  logic [CH_W-1:0] rd_data;

  assign cfg_ok  = cfg_we && !busy;
  assign list_ok = list_we && !busy;

  always_comb begin
    sel_d    = sel_q;
    ticks_d  = ticks_q;
    delay_d  = delay_q;
    outsel_d = outsel_q;
    len_d    = len_q;
    if (cfg_ok) begin
      sel_d    = tb_sel_t'(cfg_tb_sel);
      ticks_d  = cfg_ticks;
      delay_d  = cfg_delay;
      outsel_d = cfg_out_sel;
      len_d    = (cfg_len > LW'(MAX_LIST)) ? LW'(MAX_LIST) : cfg_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= TB_FAST;
      ticks_q  <= TICK_W'(DEFAULT_TICKS);
      delay_q  <= 1'b1;
      outsel_q <= 2'b11;
      len_q    <= LW'(1);
    end else begin
      sel_q    <= sel_d;
      ticks_q  <= ticks_d;
      delay_q  <= delay_d;
      outsel_q <= outsel_d;
      len_q    <= len_d;
    end
  end

  scan_timebase #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (launch),
    .sel     (sel_q),
    .tb_tick (tb_tick)
  );

  scan_spacer #(.TICK_W(TICK_W)) u_space (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (launch),
    .tb_tick (tb_tick),
    .ticks   (ticks_q),
    .fire    (fire)
  );

  scan_chanlist #(.MAX_LIST(MAX_LIST), .CH_W(CH_W)) u_list (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (list_ok),
    .wr_addr (list_addr),
    .wr_data (list_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  scan_sequencer #(.MAX_LIST(MAX_LIST), .CH_W(CH_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .fire    (fire),
    .delay   (delay_q),
    .len     (len_q),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .launch  (launch),
    .scan_p  (scan_p),
    .conv_p  (conv_p),
    .chan    (conv_chan),
    .busy    (busy)
  );

  assign scan_strobe = scan_p & outsel_q[OUT_SCAN_BIT];
  assign conv_strobe = conv_p & outsel_q[OUT_CONV_BIT];

  a_r1_scan_single: assert property (@(posedge clk) disable iff (!rst_n)
    scan_strobe |=> !scan_strobe);

  a_r2_conv_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |=> !conv_strobe);

  a_r7_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_strobe || conv_strobe) |-> busy);

  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ticks_q) && $stable(len_q) && $stable(sel_q)));

  a_r12_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(conv_chan));

endmodule

// File: tb/tb_scan_conv_timer.sv
module tb_scan_conv_timer;
  localparam int FAST_DIV = 2;
  localparam int SLOW_DIV = 5;
  localparam int MAX_LIST = 8;
  localparam int CH_W     = 6;
  localparam int TICK_W   = 16;
  localparam int LW       = $clog2(MAX_LIST + 1);
  localparam int AW       = $clog2(MAX_LIST);

  logic              clk;
  logic              rst_n;
  logic              cfg_we;
  logic [1:0]        cfg_tb_sel;
  logic [TICK_W-1:0] cfg_ticks;
  logic              cfg_delay;
  logic [1:0]        cfg_out_sel;
  logic [LW-1:0]     cfg_len;
  logic              list_we;
  logic [AW-1:0]     list_addr;
  logic [CH_W-1:0]   list_data;
  logic              start;
  logic              scan_strobe;
  logic              conv_strobe;
  logic [CH_W-1:0]   conv_chan;
  logic              busy;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // model of the configuration the block should hold
  int m_sel, m_ticks, m_delay, m_out, m_len;
  int m_list [MAX_LIST];

  scan_conv_timer #(
    .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .MAX_LIST(MAX_LIST),
    .CH_W(CH_W), .TICK_W(TICK_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tb_sel(cfg_tb_sel),
    .cfg_ticks(cfg_ticks), .cfg_delay(cfg_delay), .cfg_out_sel(cfg_out_sel),
    .cfg_len(cfg_len), .list_we(list_we), .list_addr(list_addr),
    .list_data(list_data), .start(start), .scan_strobe(scan_strobe),
    .conv_strobe(conv_strobe), .conv_chan(conv_chan), .busy(busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic write_cfg(input int sel, input int ticks, input int dly,
                           input int outs, input int len);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tb_sel = 2'(sel); cfg_ticks = TICK_W'(ticks);
    cfg_delay = dly[0]; cfg_out_sel = 2'(outs); cfg_len = LW'(len);
    @(negedge clk);
    cfg_we = 1'b0;
    m_sel = sel; m_ticks = ticks; m_delay = dly; m_out = outs;
    m_len = (len > MAX_LIST) ? MAX_LIST : len;
  endtask

  task automatic write_list(input int addr, input int data);
    @(negedge clk);
    list_we = 1'b1; list_addr = AW'(addr); list_data = CH_W'(data);
    @(negedge clk);
    list_we = 1'b0;
    m_list[addr] = data;
  endtask

  // poke: 0 none, 1 extra start mid-scan, 2 config and list write mid-scan
  task automatic run_scan(input string tag, input int poke);
    int p, t, iv, first, last_k, win, d;
    bit hit, e_scan, e_conv, e_busy;
    p = (m_sel == 0) ? FAST_DIV : (m_sel == 1) ? 2*FAST_DIV :
        (m_sel == 2) ? SLOW_DIV : 2*SLOW_DIV;
    t = (m_ticks < 2) ? 2 : m_ticks;
    iv = p * t;
    first = m_delay ? iv : 0;
    last_k = (m_len == 0) ? 0 : first + (m_len - 1) * iv;
    win = last_k + 4;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k <= win; k++) begin
      if (k > 0) @(negedge clk);
      if (poke == 1) start = (k == 3);
      if (poke == 2) begin
        cfg_we = (k == 3); list_we = (k == 3);
        cfg_tb_sel = 2'd3; cfg_ticks = TICK_W'(9); cfg_delay = 1'b0;
        cfg_out_sel = 2'd0; cfg_len = LW'(1);
        list_addr = '0; list_data = CH_W'(7);
      end
      d = k - first;
      hit = (m_len > 0) && (k >= first) && (d % iv == 0) && (d / iv < m_len);
      e_scan = (k == 0) && m_out[1];
      e_conv = hit && m_out[0];
      e_busy = (k <= last_k);
      check(scan_strobe == e_scan, $sformatf("%s R1 scan strobe k=%0d", tag, k),
            scan_strobe, e_scan);
      check(conv_strobe == e_conv, $sformatf("%s R3/R4 conv strobe k=%0d", tag, k),
            conv_strobe, e_conv);
      check(busy == e_busy, $sformatf("%s R7 busy k=%0d", tag, k), busy, e_busy);
      if (hit)
        check(conv_chan == CH_W'(m_list[d / iv]),
              $sformatf("%s R2 channel k=%0d", tag, k), conv_chan, m_list[d / iv]);
    end
    start = 1'b0; cfg_we = 1'b0; list_we = 1'b0;
    if (m_len > 0)
      check(conv_chan == CH_W'(m_list[m_len-1]), $sformatf("%s R12 channel held", tag),
            conv_chan, m_list[m_len-1]);
  endtask

  task automatic t_reset();
    check(scan_strobe == 1'b0, "R11 reset scan strobe", scan_strobe, 0);
    check(conv_strobe == 1'b0, "R11 reset conv strobe", conv_strobe, 0);
    check(busy == 1'b0, "R11 reset busy", busy, 0);
    check(conv_chan == '0, "R11 reset channel", conv_chan, 0);
    run_scan("R11 default", 0);
  endtask

  task automatic t_load_list();
    int vals [MAX_LIST] = '{9, 2, 63, 5, 17, 0, 40, 33};
    for (int i = 0; i < MAX_LIST; i++) write_list(i, vals[i]);
  endtask

  task automatic t_delay();
    write_cfg(0, 3, 0, 3, 4); run_scan("R4 delay off", 0);
    write_cfg(0, 3, 1, 3, 4); run_scan("R4 delay on", 0);
  endtask

  task automatic t_timebases();
    for (int s = 1; s < 4; s++) begin
      write_cfg(s, 3, 1, 3, 3);
      run_scan($sformatf("R3 select %0d", s), 0);
    end
  endtask

  task automatic t_clamp();
    write_cfg(0, 0, 0, 3, 3); run_scan("R5 ticks 0", 0);
    write_cfg(0, 1, 1, 3, 3); run_scan("R5 ticks 1", 0);
  endtask

  task automatic t_gating();
    for (int o = 0; o < 3; o++) begin
      write_cfg(0, 2, 0, o, 3);
      run_scan($sformatf("R6 out %0d", o), 0);
    end
  endtask

  task automatic t_empty();
    write_cfg(1, 3, 1, 3, 0); run_scan("R9 empty list", 0);
  endtask

  task automatic t_full();
    write_cfg(0, 2, 0, 3, 12);
    check(m_len == MAX_LIST, "R2 length clamp model", m_len, MAX_LIST);
    run_scan("R2 full list", 0);
  endtask

  task automatic t_busy_start();
    write_cfg(1, 3, 1, 3, 4); run_scan("R8 start while busy", 1);
  endtask

  task automatic t_busy_writes();
    write_cfg(0, 3, 1, 3, 4);
    run_scan("R10 writes while busy", 2);
    run_scan("R10 after dropped writes", 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_tb_sel = '0; cfg_ticks = '0; cfg_delay = 1'b0;
    cfg_out_sel = '0; cfg_len = '0; list_we = 1'b0; list_addr = '0; list_data = '0;
    start = 1'b0;
    m_sel = 0; m_ticks = 20; m_delay = 1; m_out = 3; m_len = 1;
    for (int i = 0; i < MAX_LIST; i++) m_list[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_list();
    t_delay();
    t_timebases();
    t_clamp();
    t_gating();
    t_empty();
    t_full();
    t_busy_start();
    t_busy_writes();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule